// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transmitter

This block turns a byte plus one extra control bit into an 11-bit asynchronous frame on a single serial line. A frame is a low start bit, the eight data bits with the least significant bit first, the extra ninth bit, and a high stop bit. The ninth bit is often used as an address/data marker or as parity computed by software.

Bit timing comes from a sample-rate enable `tick_x16`, which pulses for one clock cycle at sixteen times the bit rate. Outside the block it is produced by dividing the oscillator by 2 or by 4, depending on a double-rate selection, so the bit rate is the oscillator divided by 32 or 64. Inside the block, a divide-by-16 counter runs freely on that enable. A byte write does not start the line at once. Every bit boundary, the first one included, falls on a rollover of that shared counter. When the stop bit goes onto the line, a completion flag is raised, and it stays up until software pulses the clear input.

Top module: `ser9_tx`

## Requirements
- R1: After reset `txd` is 1 and `txc_flag` is 0, and the line stays at 1 whenever no frame is in progress.
- R2: A frame sends a start bit at 0 and then `wr_data` bits 0 through 7 in that order. Each bit is held on `txd` for exactly 16 `tick_x16` pulses.
- R3: The divide-by-16 counter starts at 0 after reset and advances on every `tick_x16` pulse, whether or not a frame is running. A rollover is the pulse that takes it from 15 to 0. The start bit appears at the first rollover strictly after the clock edge that accepted the write. A write accepted on a rollover edge therefore starts the frame 16 pulses later.
- R4: `txd` changes value only at the clock edge of a rollover pulse.
- R5: The value of `bit9` sampled with the accepted write is sent as the tenth bit on the line, directly after data bit 7.
- R6: At the 11th rollover after the write, `txd` goes to 1 for the stop bit and `txc_flag` is set on the same clock edge.
- R7: `txc_flag` stays at 1 until a cycle with `flag_clr` at 1, and reads 0 from the next clock edge on.
- R8: A write made while a frame is in progress (from the accepted write until the stop-bit rollover) has no effect on the frame being sent and starts no extra frame.
- R9: A write is accepted at any time after the stop-bit rollover, even with `txc_flag` still set. A write issued straight after the flag rises gives a stop bit exactly 16 pulses long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_x16 | input | 1 | One-cycle enable at sixteen times the bit rate |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| bit9 | input | 1 | Ninth bit value, sampled with the write |
| flag_clr | input | 1 | Clear pulse for the completion flag |
| txd | output | 1 | Serial line, idles high |
| txc_flag | output | 1 | Transmit-complete flag |

## Verification
If the bit index is corrupted, the frame is either cut short or stretched. The flag then rises earlier or later than 160 pulses after the falling start edge, which is visible at the end of the first frame. A counter phase that drifts away from the free-running count moves the start edge off the rollover, so the measured write-to-start lead is wrong on the very next write. A shift register that loads while busy, or that fills with the wrong value, shows up as a wrong mid-bit sample within one bit time of the fault.

// File: rtl/ser9_pkg.sv
package ser9_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_ARMED = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/ser9_rst_sync.sv
module ser9_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/ser9_div16.sv
module ser9_div16 #(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic roll
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = cnt_q;
    if (tick) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_d;
    end
  end

  assign roll = tick & wrap;

  // R3: the counter holds its value on every cycle without a tick
  p_counter_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/ser9_shifter.sv
module ser9_shifter
  import ser9_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              roll,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9,
  output logic              txd,
  output logic              done
);
  localparam int SHIFT_W = DATA_W + 2;
  localparam int IDX_W   = $clog2(SHIFT_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SHIFT_W - 1);

  tx_state_e          state_q, state_d;
  logic [SHIFT_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               txd_q, txd_d;

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    idx_d   = idx_q;
    txd_d   = txd_q;
    done    = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (wr_en) begin
          state_d = TX_ARMED;
          sh_d    = {1'b1, bit9, wr_data};
        end
      end
      TX_ARMED: begin
        if (roll) begin
          state_d = TX_SHIFT;
          txd_d   = 1'b0;
          idx_d   = '0;
        end
      end
      TX_SHIFT: begin
        if (roll) begin
          txd_d = sh_q[0];
          sh_d  = {1'b1, sh_q[SHIFT_W-1:1]};
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_LAST) begin
            state_d = TX_IDLE;
            done    = 1'b1;
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      sh_q    <= '1;
      idx_q   <= '0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      idx_q   <= idx_d;
      txd_q   <= txd_d;
    end
  end

  assign txd = txd_q;

  // R1: no frame in progress means the line rests high
  p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_IDLE) |-> txd_q);

  // R8: a write during a frame leaves the frame contents untouched
  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != TX_IDLE) && wr_en && !roll) |=> $stable(sh_q));
endmodule

// File: rtl/ser9_flag.sv
module ser9_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R7: the flag holds without a clear
  p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R7: a clear with no new completion drops the flag
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/ser9_tx.sv
module ser9_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              tick_x16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9,
  input  logic              flag_clr,
  output logic              txd,
  output logic              txc_flag
);
  logic rst_n_s;
  logic roll;
  logic done;

  ser9_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_s (rst_n_s)
  );

  ser9_div16 #(.OVS(OVS)) u_div (
    .clk   (clk),
    .rst_n (rst_n_s),
    .tick  (tick_x16),
    .roll  (roll)
  );

  ser9_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .roll    (roll),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .bit9    (bit9),
    .txd     (txd),
    .done    (done)
  );

  ser9_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_i  (done),
    .clr_i  (flag_clr),
    .flag_o (txc_flag)
  );

  // R4: the line moves only on a rollover edge
  p_line_moves_on_roll_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (txd != $past(txd)) |-> $past(roll));

  // R6: the flag rises together with the stop bit on a rollover
  p_flag_with_stop_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(txc_flag) |-> (txd && $past(roll)));
endmodule

// File: tb/ser9_tx_tb.sv
`timescale 1ns/1ps
module ser9_tx_tb_top;
  logic       clk = 1'b0;
  logic       arst_n;
  logic       tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       bit9;
  logic       flag_clr;
  logic       txd;
  logic       txc_flag;

  int         n_checks = 0;
  int         n_fail   = 0;
  int         tick_period = 4;
  logic       tick_run = 1'b0;
  int         tdiv = 0;
  logic [3:0] cnt_m = '0;
  int         gticks = 0;
  logic [8:0] exp_q[$];
  logic       summary_done = 1'b0;

  always #2.5 clk = ~clk;

  ser9_tx dut_i (
    .clk      (clk),
    .arst_n   (arst_n),
    .tick_x16 (tick),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .bit9     (bit9),
    .flag_clr (flag_clr),
    .txd      (txd),
    .txc_flag (txc_flag)
  );

  always @(negedge clk) begin
    if (!tick_run) begin
      tick <= 1'b0;
      tdiv <= 0;
    end else if (tdiv >= tick_period - 1) begin
      tick <= 1'b1;
      tdiv <= 0;
    end else begin
      tick <= 1'b0;
      tdiv <= tdiv + 1;
    end
  end

  // independent model of the free-running counter (R3)
  always @(posedge clk) begin
    if (!tick_run) cnt_m <= '0;
    else if (tick) cnt_m <= cnt_m + 4'd1;
    if (tick_run && tick) gticks <= gticks + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      do @(posedge clk); while (tick !== 1'b1);
    end
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    logic prev = 1'b1;
    forever begin
      @(negedge clk);
      if (tick_run && prev === 1'b1 && txd === 1'b0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected frame", 1, 0);
        end else begin
          logic [8:0] e;
          logic       pre_flag;
          e = exp_q.pop_front();
          pre_flag = txc_flag;
          wait_ticks(8);
          check(txd === 1'b0, "R2 start bit", int'(txd), 0);
          for (int i = 0; i < 8; i++) begin
            wait_ticks(16);
            check(txd === e[i], "R2 data bit", int'(txd), int'(e[i]));
          end
          wait_ticks(16);
          check(txd === e[8], "R5 ninth bit", int'(txd), int'(e[8]));
          wait_ticks(7);
          check(txd === e[8], "R4 ninth bit held 16 ticks", int'(txd), int'(e[8]));
          if (!pre_flag)
            check(txc_flag === 1'b0, "R6 flag early", int'(txc_flag), 0);
          wait_ticks(1);
          check(txd === 1'b1, "R6 stop bit", int'(txd), 1);
          check(txc_flag === 1'b1, "R6 flag with stop", int'(txc_flag), 1);
        end
      end
      prev = txd;
    end
  end

  // driver: write and check the lead to the start edge (R3)
  task automatic do_write(input logic [7:0] d, input logic b9, input bit push,
                          input bit check_lead);
    int lead_exp;
    int g0;
    @(negedge clk); #1;
    wr_en = 1'b1; wr_data = d; bit9 = b9;
    lead_exp = 16 - ((int'(cnt_m) + int'(tick)) % 16);
    if (push) exp_q.push_back({b9, d});
    @(negedge clk);
    g0 = gticks;
    #1;
    wr_en = 1'b0; wr_data = 8'h00; bit9 = 1'b0;
    if (check_lead) begin
      int guard = 0;
      while (txd !== 1'b0 && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
      check(gticks - g0 == lead_exp, "R3 start on next rollover", gticks - g0, lead_exp);
    end
  endtask

  task automatic wait_flag();
    int guard = 0;
    while (txc_flag !== 1'b1 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(txc_flag === 1'b1, "R6 flag arrives", int'(txc_flag), 1);
  endtask

  task automatic pulse_clear();
    @(negedge clk); #1;
    flag_clr = 1'b1;
    @(negedge clk); #1;
    flag_clr = 1'b0;
  endtask

  initial begin
    #750000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    arst_n = 1'b0; wr_en = 1'b0; wr_data = '0; bit9 = 1'b0; flag_clr = 1'b0;
    repeat (4) @(negedge clk);
    check(txd === 1'b1, "R1 reset line", int'(txd), 1);
    check(txc_flag === 1'b0, "R1 reset flag", int'(txc_flag), 0);
    #1 arst_n = 1'b1;
    repeat (6) @(negedge clk);
    tick_run = 1'b1;

    // slow rate, one frame
    tick_period = 4;
    repeat (37) @(negedge clk);
    check(txd === 1'b1, "R1 idle high", int'(txd), 1);
    do_write(8'hA5, 1'b1, 1'b1, 1'b1);
    wait_flag();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(txc_flag === 1'b1, "R7 flag holds", int'(txc_flag), 1);
    end
    pulse_clear();
    check(txc_flag === 1'b0, "R7 flag cleared", int'(txc_flag), 0);

    // fast rate, write during frame ignored, back-to-back with flag still set
    tick_period = 2;
    wait_ticks(5);
    do_write(8'h3C, 1'b0, 1'b1, 1'b1);
    wait_ticks(40);
    do_write(8'hFF, 1'b1, 1'b0, 1'b0);
    wait_ticks(40);
    do_write(8'h00, 1'b0, 1'b0, 1'b0);
    wait_flag();
    begin
      int t0;
      int guard = 0;
      t0 = gticks;
      do_write(8'h81, 1'b1, 1'b1, 1'b0);
      while (txd !== 1'b0 && guard < 1000) begin
        @(negedge clk);
        guard++;
      end
      check(gticks - t0 == 16, "R9 stop bit length", gticks - t0, 16);
    end
    pulse_clear();
    wait_flag();
    pulse_clear();

    // write landing on a rollover edge
    do @(negedge clk); while (!(cnt_m == 4'd15 && tick == 1'b0 && tdiv == tick_period - 1));
    do_write(8'h5A, 1'b0, 1'b1, 1'b1);
    wait_flag();
    pulse_clear();

    // more patterns at the slow rate
    tick_period = 4;
    wait_ticks(3);
    do_write(8'h00, 1'b1, 1'b1, 1'b1);
    wait_flag();
    pulse_clear();
    do_write(8'hFF, 1'b0, 1'b1, 1'b1);
    wait_flag();
    pulse_clear();

    // nothing further goes out
    begin
      bit stayed = 1'b1;
      for (int k = 0; k < 64 * 4; k++) begin
        @(negedge clk);
        if (txd !== 1'b1) stayed = 1'b0;
      end
      check(stayed, "R8 no extra frame", int'(stayed), 1);
      check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    end
    finish_run();
  end
endmodule